// File: doc/BRIEF.md
# Pipelined Floating-Point Adder-Subtractor

This block adds or subtracts two binary floating-point operands in four registered segments. Each operand is a sign bit, a magnitude read as a binary fraction, and a two's-complement exponent. Its value is (-1)^sign × magnitude × 2^exponent. A nonzero operand is normalized, so the top magnitude bit is set and the magnitude lies in [0.5, 1). The result comes back in the same normalized form, and two flags report exponent overflow and underflow.

The four segments, in order, are:

1. Exponent compare: picks the operand with the larger exponent and the distance between the exponents.
2. Alignment: shifts the other magnitude right by that distance.
3. Add/subtract: combines the two signed magnitudes.
4. Normalization: fixes a carry or leading zeros and adjusts the exponent.

An operation may enter on every clock. Its result appears four clocks later, marked by the output valid strobe. Results appear in issue order. There is no back-pressure.

Top module: `fpa_pipe_top`

## Requirements
- R1: Operand and result format. The sign bit is 1 for negative. The magnitude is MANT_W bits, and bit MANT_W-1 has weight 1/2. The exponent is EXP_W-bit two's complement. A zero has magnitude 0. Every nonzero result has magnitude bit MANT_W-1 set.
- R2: `in_sub` = 0 gives A + B. `in_sub` = 1 gives A - B, which is done by inverting the sign of B.
- R3: The provisional result exponent is the larger of the two exponents. A zero operand's exponent is ignored, so a zero never wins the compare. On equal exponents, A is taken as the larger.
- R4: The magnitude of the operand with the smaller exponent is shifted right by the exponent difference. Bits shifted out are dropped without rounding. A difference of MANT_W or more yields a zero aligned magnitude.
- R5: When the effective signs match, the magnitudes are added and the result takes their common sign. When they differ, the smaller magnitude is subtracted from the larger and the result takes the larger one's sign. On equal magnitudes, B's aligned value counts as the larger one.
- R6: A sum of 1 or more is shifted right by one place, dropping the LSB, and the exponent is incremented by one.
- R7: A result with k leading zeros below the binary point is shifted left by k places, and the exponent is decremented by k.
- R8: A zero combination result is output as magnitude 0, sign 0 and exponent 0, with both flags clear.
- R9: If the increment of R6 would pass the largest exponent, `out_ovf` is set. The exponent is then held at its maximum and the right-shifted magnitude is kept.
- R10: If the decrement of R7 would fall below the smallest exponent, `out_unf` is set and the result is forced to the R8 zero.
- R11: `out_valid` equals `in_valid` from four clocks earlier, with one result per accepted operation in issue order. Reset (active-low `rst_n`) clears all valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_sub | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of A |
| a_mag | input | MANT_W | Fractional magnitude of A |
| a_exp | input | EXP_W | Two's-complement exponent of A |
| b_sign | input | 1 | Sign of B |
| b_mag | input | MANT_W | Fractional magnitude of B |
| b_exp | input | EXP_W | Two's-complement exponent of B |
| out_valid | output | 1 | Result strobe |
| out_sign | output | 1 | Result sign |
| out_mag | output | MANT_W | Normalized result magnitude |
| out_exp | output | EXP_W | Result exponent |
| out_ovf | output | 1 | Exponent overflow |
| out_unf | output | 1 | Exponent underflow |

## Verification
The hardest conditions to reach are the exponent flags. A flag needs an extreme exponent together with the right mantissa event: a carry at the largest exponent, or a cancellation near the smallest one that leaves several leading zeros. The bench shrinks the block to 4-bit magnitudes and 4-bit exponents. It then sweeps every sign and normalized magnitude, including zero, against a set of exponents that holds both range limits and near-equal and far-apart pairs, in both operations. This drives every carry, every cancellation depth and every out-of-range shift against both limits. Idle gaps are inserted into the stream to test the valid timing.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    localparam int FPA_MANT_W = 8;
    localparam int FPA_EXP_W  = 6;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } fpa_op_e;
endpackage

// File: rtl/fpa_seg_cmp.sv
module fpa_seg_cmp
    import fpa_pkg::*;
#(
    parameter int MANT_W = FPA_MANT_W,
    parameter int EXP_W  = FPA_EXP_W,
    localparam int SH_W  = $clog2(MANT_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sub,
    input  logic                    a_sign,
    input  logic [MANT_W-1:0]       a_mag,
    input  logic signed [EXP_W-1:0] a_exp,
    input  logic                    b_sign,
    input  logic [MANT_W-1:0]       b_mag,
    input  logic signed [EXP_W-1:0] b_exp,
    output logic                    v_q,
    output logic                    big_sign_q,
    output logic [MANT_W-1:0]       big_mag_q,
    output logic                    small_sign_q,
    output logic [MANT_W-1:0]       small_mag_q,
    output logic [SH_W-1:0]         sh_q,
    output logic signed [EXP_W-1:0] exp_q
);
    fpa_op_e                 op;
    logic                    b_eff;
    logic                    pick_b;
    logic                    big_sign, small_sign;
    logic [MANT_W-1:0]       big_mag, small_mag;
    logic signed [EXP_W-1:0] big_exp, small_exp;
    logic [SH_W-1:0]         sh;
    int                      diff_i;

    always_comb begin
        op     = fpa_op_e'(in_sub);
        b_eff  = b_sign ^ (op == OP_SUB);
        pick_b = (a_mag == '0) || ((b_mag != '0) && (b_exp > a_exp));
        if (pick_b) begin
            big_sign   = b_eff;   big_mag   = b_mag;   big_exp   = b_exp;
            small_sign = a_sign;  small_mag = a_mag;   small_exp = a_exp;
        end else begin
            big_sign   = a_sign;  big_mag   = a_mag;   big_exp   = a_exp;
            small_sign = b_eff;   small_mag = b_mag;   small_exp = b_exp;
        end
        diff_i = int'(big_exp) - int'(small_exp);
        if (small_mag == '0)
            sh = '0;
        else if (diff_i >= MANT_W)
            sh = SH_W'(MANT_W);
        else
            sh = SH_W'(diff_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q          <= 1'b0;
            big_sign_q   <= 1'b0;
            big_mag_q    <= '0;
            small_sign_q <= 1'b0;
            small_mag_q  <= '0;
            sh_q         <= '0;
            exp_q        <= '0;
        end else begin
            v_q          <= in_valid;
            big_sign_q   <= big_sign;
            big_mag_q    <= big_mag;
            small_sign_q <= small_sign;
            small_mag_q  <= small_mag;
            sh_q         <= sh;
            exp_q        <= big_exp;
        end
    end

    // R3: with two nonzero operands the chosen exponent dominates both inputs
    assert_big_exp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_mag != '0 && b_mag != '0) |=>
            (exp_q >= $past(a_exp) && exp_q >= $past(b_exp)));
endmodule

// File: rtl/fpa_seg_align.sv
module fpa_seg_align
    import fpa_pkg::*;
#(
    parameter int MANT_W = FPA_MANT_W,
    parameter int EXP_W  = FPA_EXP_W,
    localparam int SH_W  = $clog2(MANT_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_in,
    input  logic                    big_sign,
    input  logic [MANT_W-1:0]       big_mag,
    input  logic                    small_sign,
    input  logic [MANT_W-1:0]       small_mag,
    input  logic [SH_W-1:0]         sh,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic                    v_q,
    output logic                    big_sign_q,
    output logic [MANT_W-1:0]       big_mag_q,
    output logic                    small_sign_q,
    output logic [MANT_W-1:0]       al_mag_q,
    output logic signed [EXP_W-1:0] exp_q
);
    logic [MANT_W-1:0] al_mag;

    always_comb begin
        if (int'(sh) >= MANT_W)
            al_mag = '0;
        else
            al_mag = small_mag >> sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q          <= 1'b0;
            big_sign_q   <= 1'b0;
            big_mag_q    <= '0;
            small_sign_q <= 1'b0;
            al_mag_q     <= '0;
            exp_q        <= '0;
        end else begin
            v_q          <= v_in;
            big_sign_q   <= big_sign;
            big_mag_q    <= big_mag;
            small_sign_q <= small_sign;
            al_mag_q     <= al_mag;
            exp_q        <= exp_in;
        end
    end

    // R4: alignment only ever discards magnitude, never adds to it
    assert_align_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> (al_mag_q <= $past(small_mag)));
endmodule

// File: rtl/fpa_seg_addsub.sv
module fpa_seg_addsub
    import fpa_pkg::*;
#(
    parameter int MANT_W = FPA_MANT_W,
    parameter int EXP_W  = FPA_EXP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_in,
    input  logic                    big_sign,
    input  logic [MANT_W-1:0]       big_mag,
    input  logic                    small_sign,
    input  logic [MANT_W-1:0]       al_mag,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic                    v_q,
    output logic                    sign_q,
    output logic [MANT_W:0]         sum_q,
    output logic signed [EXP_W-1:0] exp_q
);
    logic           same;
    logic           sgn;
    logic [MANT_W:0] sum;

    always_comb begin
        same = (big_sign == small_sign);
        if (same) begin
            sum = {1'b0, big_mag} + {1'b0, al_mag};
            sgn = big_sign;
        end else if (big_mag > al_mag) begin
            sum = {1'b0, big_mag} - {1'b0, al_mag};
            sgn = big_sign;
        end else begin
            sum = {1'b0, al_mag} - {1'b0, big_mag};
            sgn = small_sign;
        end
        if (sum == '0)
            sgn = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            sign_q <= 1'b0;
            sum_q  <= '0;
            exp_q  <= '0;
        end else begin
            v_q    <= v_in;
            sign_q <= sgn;
            sum_q  <= sum;
            exp_q  <= exp_in;
        end
    end

    // R6: a carry out of the fraction needs two magnitudes of the same sign
    assert_carry_same_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && big_sign != small_sign) |=> !sum_q[MANT_W]);
endmodule

// File: rtl/fpa_seg_norm.sv
module fpa_seg_norm
    import fpa_pkg::*;
#(
    parameter int MANT_W = FPA_MANT_W,
    parameter int EXP_W  = FPA_EXP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_in,
    input  logic                    sign_in,
    input  logic [MANT_W:0]         sum_in,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic                    v_q,
    output logic                    sign_q,
    output logic [MANT_W-1:0]       mag_q,
    output logic signed [EXP_W-1:0] exp_q,
    output logic                    ovf_q,
    output logic                    unf_q
);
    localparam int EMAX = (1 << (EXP_W - 1)) - 1;
    localparam int EMIN = -(1 << (EXP_W - 1));

    int                      lz;
    int                      e_i;
    logic                    sgn;
    logic [MANT_W-1:0]       mag;
    logic signed [EXP_W-1:0] ex;
    logic                    ovf, unf;

    always_comb begin
        lz = MANT_W;
        for (int i = 0; i < MANT_W; i++) begin
            if (sum_in[i])
                lz = MANT_W - 1 - i;
        end
        sgn = sign_in;
        mag = '0;
        ex  = '0;
        ovf = 1'b0;
        unf = 1'b0;
        e_i = int'(exp_in);
        if (sum_in == '0) begin
            sgn = 1'b0;
        end else if (sum_in[MANT_W]) begin
            mag = sum_in[MANT_W:1];
            e_i = int'(exp_in) + 1;
            if (e_i > EMAX) begin
                ovf = 1'b1;
                ex  = EXP_W'(EMAX);
            end else begin
                ex  = EXP_W'(e_i);
            end
        end else begin
            e_i = int'(exp_in) - lz;
            if (e_i < EMIN) begin
                unf = 1'b1;
                sgn = 1'b0;
            end else begin
                mag = sum_in[MANT_W-1:0] << lz;
                ex  = EXP_W'(e_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            sign_q <= 1'b0;
            mag_q  <= '0;
            exp_q  <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            v_q    <= v_in;
            sign_q <= sgn;
            mag_q  <= mag;
            exp_q  <= ex;
            ovf_q  <= ovf;
            unf_q  <= unf;
        end
    end

    // R1: every nonzero result leaves with its top fraction bit set
    assert_norm_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && mag_q != '0) |-> mag_q[MANT_W-1]);

    // R8: a zero result is canonical
    assert_zero_canon_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && mag_q == '0) |-> (exp_q == '0 && !sign_q && !ovf_q));

    // R9: the two exponent flags never coincide
    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> !(ovf_q && unf_q));

    // R10: an underflow always delivers zero
    assert_unf_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && unf_q) |-> (mag_q == '0));
endmodule

// File: rtl/fpa_pipe_top.sv
module fpa_pipe_top
    import fpa_pkg::*;
#(
    parameter int MANT_W = FPA_MANT_W,
    parameter int EXP_W  = FPA_EXP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sub,
    input  logic                    a_sign,
    input  logic [MANT_W-1:0]       a_mag,
    input  logic signed [EXP_W-1:0] a_exp,
    input  logic                    b_sign,
    input  logic [MANT_W-1:0]       b_mag,
    input  logic signed [EXP_W-1:0] b_exp,
    output logic                    out_valid,
    output logic                    out_sign,
    output logic [MANT_W-1:0]       out_mag,
    output logic signed [EXP_W-1:0] out_exp,
    output logic                    out_ovf,
    output logic                    out_unf
);
    localparam int SH_W = $clog2(MANT_W + 1);

    logic                    s1_v, s1_bs, s1_ss;
    logic [MANT_W-1:0]       s1_bm, s1_sm;
    logic [SH_W-1:0]         s1_sh;
    logic signed [EXP_W-1:0] s1_e;

    logic                    s2_v, s2_bs, s2_ss;
    logic [MANT_W-1:0]       s2_bm, s2_am;
    logic signed [EXP_W-1:0] s2_e;

    logic                    s3_v, s3_s;
    logic [MANT_W:0]         s3_sum;
    logic signed [EXP_W-1:0] s3_e;

    fpa_seg_cmp #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
        .a_sign(a_sign), .a_mag(a_mag), .a_exp(a_exp),
        .b_sign(b_sign), .b_mag(b_mag), .b_exp(b_exp),
        .v_q(s1_v), .big_sign_q(s1_bs), .big_mag_q(s1_bm),
        .small_sign_q(s1_ss), .small_mag_q(s1_sm), .sh_q(s1_sh), .exp_q(s1_e)
    );

    fpa_seg_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
        .clk(clk), .rst_n(rst_n), .v_in(s1_v),
        .big_sign(s1_bs), .big_mag(s1_bm), .small_sign(s1_ss),
        .small_mag(s1_sm), .sh(s1_sh), .exp_in(s1_e),
        .v_q(s2_v), .big_sign_q(s2_bs), .big_mag_q(s2_bm),
        .small_sign_q(s2_ss), .al_mag_q(s2_am), .exp_q(s2_e)
    );

    fpa_seg_addsub #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_addsub (
        .clk(clk), .rst_n(rst_n), .v_in(s2_v),
        .big_sign(s2_bs), .big_mag(s2_bm), .small_sign(s2_ss),
        .al_mag(s2_am), .exp_in(s2_e),
        .v_q(s3_v), .sign_q(s3_s), .sum_q(s3_sum), .exp_q(s3_e)
    );

    fpa_seg_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
        .clk(clk), .rst_n(rst_n), .v_in(s3_v),
        .sign_in(s3_s), .sum_in(s3_sum), .exp_in(s3_e),
        .v_q(out_valid), .sign_q(out_sign), .mag_q(out_mag),
        .exp_q(out_exp), .ovf_q(out_ovf), .unf_q(out_unf)
    );

    logic [2:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 3'd4)
            since_rst <= since_rst + 3'd1;
    end

    // R11: four-cycle latency of the valid strobe
    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));
endmodule

// File: tb/sim_fpa_pipe_top.sv
module sim_fpa_pipe_top;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 4;
    localparam int EW = 4;
    localparam int EMAX = 7;
    localparam int EMIN = -8;
    localparam int RW = MW + EW + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sub = 1'b0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [MW-1:0] a_mag = '0, b_mag = '0;
    logic signed [EW-1:0] a_exp = '0, b_exp = '0;
    logic out_valid, out_sign, out_ovf, out_unf;
    logic [MW-1:0] out_mag;
    logic signed [EW-1:0] out_exp;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [3:0]    vhist = '0;
    logic [RW-1:0] q_res [0:15];
    string         q_tag [0:15];
    int wr = 0, rd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpa_pipe_top #(.MANT_W(MW), .EXP_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
        .a_sign(a_sign), .a_mag(a_mag), .a_exp(a_exp),
        .b_sign(b_sign), .b_mag(b_mag), .b_exp(b_exp),
        .out_valid(out_valid), .out_sign(out_sign), .out_mag(out_mag),
        .out_exp(out_exp), .out_ovf(out_ovf), .out_unf(out_unf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int etab(input int i);
        case (i)
            0: return -8;
            1: return -7;
            2: return -4;
            3: return -1;
            4: return 0;
            5: return 3;
            6: return 6;
            default: return 7;
        endcase
    endfunction

    // Arithmetic reference built from R2-R10
    function automatic logic [RW-1:0] model(input int as_, input int am, input int ae,
                                            input int bs, input int bm, input int be,
                                            input int sub, output string tag);
        int bse, gs, gm, ge, ss, sm, se, sh, al, sv, m, e, lz, o, u, s;
        bse = bs ^ sub;
        if (am == 0 || (bm != 0 && be > ae)) begin
            gs = bse; gm = bm; ge = be; ss = as_; sm = am; se = ae;
        end else begin
            gs = as_; gm = am; ge = ae; ss = bse; sm = bm; se = be;
        end
        sh = ge - se;
        al = (sm == 0 || sh >= MW) ? 0 : (sm >> sh);
        sv = (gs != 0 ? -gm : gm) + (ss != 0 ? -al : al);
        o = 0; u = 0; lz = 0;
        tag = (am == 0 || bm == 0) ? "R3" : ((sub != 0) ? "R2" : "R5");
        if (sm != 0 && sh >= MW) tag = "R4";
        if (sv == 0) begin
            s = 0; m = 0; e = 0; tag = "R8";
        end else begin
            s = (sv < 0) ? 1 : 0;
            m = (sv < 0) ? -sv : sv;
            e = ge;
            if (m >= (1 << MW)) begin
                m = m >> 1; e = e + 1; tag = "R6";
                if (e > EMAX) begin o = 1; e = EMAX; tag = "R9"; end
            end else begin
                while (m < (1 << (MW - 1))) begin m = m << 1; lz++; end
                e = e - lz;
                if (lz > 0) tag = "R7";
                if (e < EMIN) begin u = 1; s = 0; m = 0; e = 0; tag = "R10"; end
            end
        end
        return {s[0], m[MW-1:0], e[EW-1:0], o[0], u[0]};
    endfunction

    task automatic check_out();
        logic [RW-1:0] r;
        string t;
        chk(out_valid == vhist[3], "R11 valid latency", int'(out_valid), int'(vhist[3]));
        if (out_valid) begin
            if (rd == wr) begin
                chk(1'b0, "R11 result without operation", 1, 0);
            end else begin
                r = q_res[rd % 16];
                t = q_tag[rd % 16];
                rd++;
                chk(out_sign == r[RW-1], {t, " sign"}, int'(out_sign), int'(r[RW-1]));
                chk(out_mag == r[RW-2:EW+2], {t, " magnitude"}, int'(out_mag), int'(r[RW-2:EW+2]));
                chk(out_exp == r[EW+1:2], {t, " exponent"}, int'(out_exp), int'($signed(r[EW+1:2])));
                chk(out_ovf == r[1], {t, " overflow flag (R9)"}, int'(out_ovf), int'(r[1]));
                chk(out_unf == r[0], {t, " underflow flag (R10)"}, int'(out_unf), int'(r[0]));
                if (out_mag != '0)
                    chk(out_mag[MW-1], "R1 normalized msb", int'(out_mag[MW-1]), 1);
            end
        end
    endtask

    task automatic step(input bit v, input int as_, input int am, input int ae,
                        input int bs, input int bm, input int be, input int sub);
        string t;
        @(negedge clk);
        check_out();
        vhist = {vhist[2:0], v};
        in_valid = v;
        in_sub = sub[0];
        a_sign = as_[0]; a_mag = am[MW-1:0]; a_exp = EW'(ae);
        b_sign = bs[0];  b_mag = bm[MW-1:0]; b_exp = EW'(be);
        if (v) begin
            q_res[wr % 16] = model(as_, am, ae, bs, bm, be, sub, t);
            q_tag[wr % 16] = t;
            wr++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R11: reset holds the output strobe and flags low
        chk(out_valid == 1'b0, "R11 reset valid", int'(out_valid), 0);
        chk(out_ovf == 1'b0 && out_unf == 1'b0, "R11 reset flags",
            int'({out_ovf, out_unf}), 0);
        rst_n = 1'b1;
        n = 0;
        for (int sub = 0; sub < 2; sub++) begin
            for (int ai = 0; ai < 144; ai++) begin
                for (int bi = 0; bi < 144; bi++) begin
                    int ka, kb;
                    ka = (ai / 2) % 9;
                    kb = (bi / 2) % 9;
                    step(1'b1, ai % 2, (ka == 0) ? 0 : 7 + ka, etab(ai / 18),
                               bi % 2, (kb == 0) ? 0 : 7 + kb, etab(bi / 18), sub);
                    n++;
                    if (n % 13 == 0)
                        step(1'b0, 0, 0, 0, 0, 0, 0, 0);
                end
            end
        end
        for (int i = 0; i < 8; i++)
            step(1'b0, 0, 0, 0, 0, 0, 0, 0);
        chk(rd == wr, "R11 result count", rd, wr);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule